// File: doc/BRIEF.md
# Gain Update Sequencer with Blanking

This block sits on the control side of a bank of programmable-gain amplifier channels. A host writes gain codes and per-channel timing counts through a simple write port. The block holds every written code in a shadow register. It copies that code into the active register, which drives the amplifier's parallel gain pins, at a moment set by the update mode. In immediate mode the copy happens straight away. In latched mode it waits for a per-channel latch pulse. In sync mode it waits for a rising edge on a shared sync line, so that a whole group of channels changes on the same clock edge.

Every change of the active code is a timed event. It opens a blanking window, and each channel's FSM walks through its states while the window is open. `ST_IDLE` moves to `ST_LATCH` on activation. `ST_LATCH` waits a fixed number of clocks for the new code to reach the analog path. It then moves to `ST_SETTLE`, which counts the programmed number of sample strobes. `ST_SETTLE` moves to `ST_MARGIN`, which counts the programmed margin strobes. `ST_MARGIN` returns to `ST_IDLE`. A state whose count is zero is skipped, so `ST_LATCH` can move directly to `ST_MARGIN` or to `ST_IDLE`.

While the window is open, the channel accepts no new activation. ADC samples arriving in the window are handled by a selectable policy: they are dropped, they are replaced by the last valid sample, or they are passed through with the valid tag low. The host can read back the shadow code, the active code and two sticky error flags for each channel.

Top module: `gain_update_seq`

## Requirements
- R1: After reset, the shadow and active codes of every channel hold the default code (1), both flags read 0 and no channel is blanking.
- R2: In immediate mode (`upd_mode`=0), an accepted gain write (`wr_sel`=0) appears in the shadow readback (`rd_sel`=0) after the write edge. It reaches the active code and `gain_out` one clock later, and that same edge raises `blank_out` for the channel.
- R3: In latched mode (`upd_mode`=1), a written code stays in the shadow register and the active code is unchanged. When a pulse on that channel's `latch_cmd` bit arrives, the active code changes two clocks after the pulse is driven.
- R4: In sync mode (`upd_mode`=2), a rising edge on `sync_in` activates every channel with a pending code on one common clock edge. Writes alone activate nothing.
- R5: After activation, all samples are invalid during the latch clocks, then for the settle count, then for the margin count of sample strobes. The next strobe after that is valid and `blank_out` falls.
- R6: With policy 0 (drop), samples inside the window produce no output.
- R7: With policy 1 (hold), each sample inside the window produces an output that carries the last valid sample's data, with `out_ok` low.
- R8: With policy 2 (tag), samples inside the window pass through with `out_ok` low. Outside the window, every sample appears one clock later with `out_vld` and `out_ok` high.
- R9: While a window is open the active code cannot change. A code written during the window stays pending and is activated as soon as the window ends, which opens a new window.
- R10: A gain write that replaces a pending, not yet activated code sets the sticky overrun flag (bit 1 of `rd_sel`=2).
- R11: A gain code of 6 or more is rejected, leaves the shadow code unchanged, and sets the sticky error flag (bit 0 of `rd_sel`=2).
- R12: The settle count (`wr_sel`=1) and the margin count (`wr_sel`=2) can be set per channel, and a value of 0 skips its phase. Reset values are 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| upd_mode | input | 2 | Activation mode: 0 immediate, 1 latched, 2 sync |
| inv_pol | input | 2 | Invalid-sample policy: 0 drop, 1 hold, 2 tag |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 1 | Channel addressed by a write |
| wr_sel | input | 2 | Written field: 0 gain, 1 settle count, 2 margin count |
| wr_data | input | 8 | Write data |
| latch_cmd | input | 2 | Per-channel latch pulse (latched mode) |
| sync_in | input | 1 | Shared sync line; its rising edge activates pending codes (sync mode) |
| rd_ch | input | 1 | Channel addressed by a read |
| rd_sel | input | 2 | Read field: 0 shadow, 1 active, 2 flags {overrun, error} |
| rd_data | output | 8 | Combinational read data |
| gain_out | output | 6 | Active codes, channel i at bits [3i+2:3i] |
| blank_out | output | 2 | Per-channel blanking window open |
| smp_vld | input | 2 | Per-channel ADC sample strobe |
| smp_data | input | 24 | Per-channel sample data, 12 bits each |
| out_vld | output | 2 | Per-channel output sample strobe |
| out_data | output | 24 | Per-channel output sample data |
| out_ok | output | 2 | Per-channel valid tag |

## Verification
The sample stream is run under all three invalid-sample policies, with several settle/margin settings including a zero margin. This shows whether the window length is counted in strobes and whether each state's skip rule holds. Writes are issued in all three activation modes. The bench then compares the active code against the shadow code before and after the trigger, which separates a write from its activation. A write issued inside an open window, followed by a second write, distinguishes deferred activation from overrun. A rejected code shows that the shadow code is left untouched. Finally, a two-channel sync edge checks that both channels change on one common edge.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
    typedef enum logic [1:0] {
        MODE_IMM   = 2'd0,
        MODE_LATCH = 2'd1,
        MODE_SYNC  = 2'd2
    } upd_mode_e;

    typedef enum logic [1:0] {
        POL_DROP = 2'd0,
        POL_HOLD = 2'd1,
        POL_TAG  = 2'd2
    } inv_pol_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_SETTLE,
        ST_MARGIN
    } chan_st_e;
endpackage

// File: rtl/gseq_chan.sv
module gseq_chan
    import gseq_pkg::*;
#(
    parameter int GW         = 3,
    parameter int CW         = 8,
    parameter int NCODES     = 6,
    parameter int DEF_CODE   = 1,
    parameter int LAT_CYC    = 2,
    parameter int DEF_SETTLE = 3,
    parameter int DEF_MARGIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          gain_we,
    input  logic          settle_we,
    input  logic          margin_we,
    input  logic [CW-1:0] wdata,
    input  logic          cmd,
    input  logic          s_vld,
    output logic [GW-1:0] shadow,
    output logic [GW-1:0] active,
    output logic          blank,
    output logic          err,
    output logic          ovr
);
    chan_st_e      st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] settle_q, margin_q;
    logic [GW-1:0] shadow_q, active_q;
    logic          pend_q, arm_q, err_q, ovr_q;
    logic          bad, ok_wr, go;

    assign bad   = gain_we && (wdata >= CW'(NCODES));
    assign ok_wr = gain_we && !bad;
    assign go    = (st_q == ST_IDLE) && pend_q &&
                   ((upd_mode_e'(mode) == MODE_IMM) || arm_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_d  = ST_LATCH;
                    cnt_d = CW'(LAT_CYC);
                end
            end
            ST_LATCH: begin
                if (cnt_q <= 1) begin
                    if (settle_q != 0) begin
                        st_d  = ST_SETTLE;
                        cnt_d = settle_q;
                    end else if (margin_q != 0) begin
                        st_d  = ST_MARGIN;
                        cnt_d = margin_q;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SETTLE: begin
                if (s_vld) begin
                    if (cnt_q == 1) begin
                        if (margin_q != 0) begin
                            st_d  = ST_MARGIN;
                            cnt_d = margin_q;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_MARGIN: begin
                if (s_vld) begin
                    if (cnt_q == 1) st_d = ST_IDLE;
                    else            cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // code registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= GW'(DEF_CODE);
            active_q <= GW'(DEF_CODE);
            settle_q <= CW'(DEF_SETTLE);
            margin_q <= CW'(DEF_MARGIN);
            pend_q   <= 1'b0;
            arm_q    <= 1'b0;
            err_q    <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (settle_we) settle_q <= wdata;
            if (margin_we) margin_q <= wdata;
            if (bad)       err_q    <= 1'b1;
            if (go) begin
                active_q <= shadow_q;
                arm_q    <= 1'b0;
            end else if (cmd && pend_q) begin
                arm_q <= 1'b1;
            end
            if (ok_wr) begin
                shadow_q <= wdata[GW-1:0];
                pend_q   <= 1'b1;
                if (pend_q && !go) ovr_q <= 1'b1;
            end else if (go) begin
                pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        shadow = shadow_q;
        active = active_q;
        blank  = (st_q != ST_IDLE);
        err    = err_q;
        ovr    = ovr_q;
    end

    // R9
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(active_q));
    // R2
    win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> (st_q == ST_LATCH));
    // R11
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(shadow_q) < NCODES);
    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
endmodule

// File: rtl/gseq_gate.sv
module gseq_gate
    import gseq_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pol,
    input  logic          blank,
    input  logic          s_vld,
    input  logic [DW-1:0] s_data,
    output logic          o_vld,
    output logic [DW-1:0] o_data,
    output logic          o_ok
);
    logic [DW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_ok   <= 1'b0;
            o_data <= '0;
            last_q <= '0;
        end else begin
            o_vld <= 1'b0;
            o_ok  <= 1'b0;
            if (s_vld) begin
                if (!blank) begin
                    o_vld  <= 1'b1;
                    o_ok   <= 1'b1;
                    o_data <= s_data;
                    last_q <= s_data;
                end else begin
                    case (inv_pol_e'(pol))
                        POL_DROP: o_vld <= 1'b0;
                        POL_HOLD: begin
                            o_vld  <= 1'b1;
                            o_data <= last_q;
                        end
                        default: begin
                            o_vld  <= 1'b1;
                            o_data <= s_data;
                        end
                    endcase
                end
            end
        end
    end

    // R8
    pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && !blank) |=> (o_vld && o_ok && o_data == $past(s_data)));
    // R6
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && blank && pol == 2'd0) |=> !o_vld);
    // R7
    blank_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && blank) |=> !o_ok);
endmodule

// File: rtl/gain_update_seq.sv
module gain_update_seq
    import gseq_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int GW         = 3,
    parameter int CW         = 8,
    parameter int DW         = 12,
    parameter int NCODES     = 6,
    parameter int DEF_CODE   = 1,
    parameter int LAT_CYC    = 2,
    parameter int DEF_SETTLE = 3,
    parameter int DEF_MARGIN = 2,
    localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        upd_mode,
    input  logic [1:0]        inv_pol,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [CW-1:0]     wr_data,
    input  logic [NCH-1:0]    latch_cmd,
    input  logic              sync_in,
    input  logic [CHW-1:0]    rd_ch,
    input  logic [1:0]        rd_sel,
    output logic [CW-1:0]     rd_data,
    output logic [NCH*GW-1:0] gain_out,
    output logic [NCH-1:0]    blank_out,
    input  logic [NCH-1:0]    smp_vld,
    input  logic [NCH*DW-1:0] smp_data,
    output logic [NCH-1:0]    out_vld,
    output logic [NCH*DW-1:0] out_data,
    output logic [NCH-1:0]    out_ok
);
    logic          sync_q, sync_rise;
    logic [GW-1:0] shadow_a [NCH];
    logic [GW-1:0] active_a [NCH];
    logic [NCH-1:0] err_a, ovr_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end
    assign sync_rise = sync_in && !sync_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit, cmd;
        assign hit = wr_en && (wr_ch == CHW'(i));
        assign cmd = (upd_mode_e'(upd_mode) == MODE_SYNC)  ? sync_rise :
                     (upd_mode_e'(upd_mode) == MODE_LATCH) ? latch_cmd[i] : 1'b0;

        gseq_chan #(
            .GW(GW), .CW(CW), .NCODES(NCODES), .DEF_CODE(DEF_CODE),
            .LAT_CYC(LAT_CYC), .DEF_SETTLE(DEF_SETTLE), .DEF_MARGIN(DEF_MARGIN)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .mode(upd_mode),
            .gain_we(hit && wr_sel == 2'd0),
            .settle_we(hit && wr_sel == 2'd1),
            .margin_we(hit && wr_sel == 2'd2),
            .wdata(wr_data), .cmd(cmd), .s_vld(smp_vld[i]),
            .shadow(shadow_a[i]), .active(active_a[i]),
            .blank(blank_out[i]), .err(err_a[i]), .ovr(ovr_a[i])
        );

        gseq_gate #(.DW(DW)) u_gate (
            .clk(clk), .rst_n(rst_n), .pol(inv_pol), .blank(blank_out[i]),
            .s_vld(smp_vld[i]), .s_data(smp_data[i*DW +: DW]),
            .o_vld(out_vld[i]), .o_data(out_data[i*DW +: DW]), .o_ok(out_ok[i])
        );

        assign gain_out[i*GW +: GW] = active_a[i];
    end

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = CW'(shadow_a[rd_ch]);
            2'd1:    rd_data = CW'(active_a[rd_ch]);
            2'd2:    rd_data = CW'({ovr_a[rd_ch], err_a[rd_ch]});
            default: rd_data = '0;
        endcase
    end
endmodule

// File: tb/sim_gain_update_seq.sv
`timescale 1ns/1ps
module sim_gain_update_seq;
    localparam int NCH = 2;
    localparam int GW  = 3;
    localparam int CW  = 8;
    localparam int DW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] upd_mode = '0, inv_pol = '0, wr_sel = '0, rd_sel = '0;
    logic wr_en = 1'b0, sync_in = 1'b0;
    logic [0:0] wr_ch = '0, rd_ch = '0;
    logic [CW-1:0] wr_data = '0, rd_data;
    logic [NCH-1:0] latch_cmd = '0, smp_vld = '0, blank_out, out_vld, out_ok;
    logic [NCH*GW-1:0] gain_out;
    logic [NCH*DW-1:0] smp_data = '0, out_data;

    int n_chk = 0, n_err = 0, base = 16;
    logic [DW-1:0] last_v = '0;
    logic [DW:0] expq [$];

    always #2 clk = ~clk;

    gain_update_seq u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rdchk(input logic ch, input logic [1:0] sel, input logic [31:0] exp, input string req);
        rd_ch = ch; rd_sel = sel;
        #0.1;
        chk(req, 32'(rd_data), exp);
    endtask

    task automatic wr(input logic ch, input logic [1:0] sel, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes expected outputs, then drives channel-0 strobes
    task automatic run_samples(input int n_inv, input int n_tot, input int pol);
        for (int i = 0; i < n_tot; i++) begin
            logic [DW-1:0] d;
            d = DW'(base);
            base++;
            if (i < n_inv) begin
                if (pol == 1)      expq.push_back({1'b0, last_v});
                else if (pol == 2) expq.push_back({1'b0, d});
            end else begin
                expq.push_back({1'b1, d});
                last_v = d;
            end
            @(negedge clk);
            smp_vld[0] = 1'b1; smp_data[DW-1:0] = d;
            @(negedge clk);
            smp_vld[0] = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // monitor: R5 R6 R7 R8
    always @(negedge clk) begin
        if (rst_n && out_vld[0]) begin
            if (expq.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R6: actual unexpected output %0h expected none", out_data[DW-1:0]);
            end else begin
                logic [DW:0] e;
                e = expq.pop_front();
                chk("R5/R7/R8 sample", 32'({out_ok[0], out_data[DW-1:0]}), 32'(e));
            end
        end
    end

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rdchk(0, 0, 1, "R1 shadow0"); rdchk(0, 1, 1, "R1 active0");
        rdchk(1, 0, 1, "R1 shadow1"); rdchk(1, 2, 0, "R1 flags1");
        @(negedge clk);
        rdchk(0, 2, 0, "R1 flags0");
        chk("R1 gain_out", 32'(gain_out), 32'h09);
        chk("R1 blank", 32'(blank_out), 0);

        // R2, R5, R6: immediate, drop
        wr(0, 0, 3);
        rdchk(0, 0, 3, "R2 shadow");
        chk("R2 active before", 32'(gain_out[2:0]), 1);
        @(negedge clk);
        chk("R2 active", 32'(gain_out[2:0]), 3);
        chk("R2 blank", 32'(blank_out[0]), 1);
        repeat (4) @(negedge clk);
        run_samples(5, 8, 0);
        chk("R5 blank end", 32'(blank_out[0]), 0);

        // R12, R7: hold with settle 1 margin 1
        inv_pol = 2'd1;
        wr(0, 1, 1); wr(0, 2, 1);
        chk("R12 no activation", 32'(blank_out[0]), 0);
        wr(0, 0, 2);
        @(negedge clk); repeat (4) @(negedge clk);
        run_samples(2, 5, 1);

        // R12, R8: tag with settle 2 margin 0
        inv_pol = 2'd2;
        wr(0, 1, 2); wr(0, 2, 0);
        wr(0, 0, 4);
        @(negedge clk); repeat (4) @(negedge clk);
        run_samples(2, 4, 2);
        chk("R12 zero margin end", 32'(blank_out[0]), 0);

        // R9: write inside window stays pending
        wr(0, 0, 5);
        @(negedge clk);
        wr(0, 0, 0);
        rdchk(0, 1, 5, "R9 active held"); rdchk(0, 0, 0, "R9 shadow pending");
        repeat (3) @(negedge clk);
        run_samples(2, 2, 2);
        rdchk(0, 1, 0, "R9 applied after window");
        chk("R9 new window", 32'(blank_out[0]), 1);
        rdchk(0, 2, 0, "R9 no overrun");
        run_samples(2, 3, 2);

        // R3, R10: latched mode
        upd_mode = 2'd1;
        wr(0, 0, 2);
        repeat (2) @(negedge clk);
        rdchk(0, 1, 0, "R3 active unchanged"); rdchk(0, 0, 2, "R3 shadow");
        rdchk(0, 2, 0, "R10 flags clear");
        wr(0, 0, 3);
        rdchk(0, 2, 2, "R10 overrun");
        @(negedge clk); latch_cmd[0] = 1'b1;
        @(negedge clk); latch_cmd[0] = 1'b0;
        rdchk(0, 1, 0, "R3 one clock after latch");
        @(negedge clk);
        rdchk(0, 1, 3, "R3 activated");
        repeat (4) @(negedge clk);
        run_samples(2, 3, 2);

        // R11: out-of-table code
        wr(0, 0, 7);
        rdchk(0, 0, 3, "R11 shadow unchanged"); rdchk(0, 2, 3, "R11 error flag");
        repeat (3) @(negedge clk);
        rdchk(0, 1, 3, "R11 active unchanged");

        // R4: sync mode group update
        upd_mode = 2'd2;
        wr(0, 0, 4); wr(1, 0, 2);
        repeat (3) @(negedge clk);
        chk("R4 no activation before edge", 32'(gain_out), 32'h0B);
        sync_in = 1'b1;
        @(negedge clk);
        chk("R4 one clock after edge", 32'(gain_out), 32'h0B);
        @(negedge clk);
        chk("R4 both changed", 32'(gain_out), 32'h14);
        chk("R4 both blanking", 32'(blank_out), 3);
        sync_in = 1'b0;

        repeat (10) @(negedge clk);
        chk("R6 all expected outputs seen", 32'(expq.size()), 0);
        finish_sim();
    end
endmodule